// File: doc/BRIEF.md
# Level-Sensitive External Interrupt Collector

This block watches a group of active-low external request pins. Each pin has its own enable bit. While any enabled pin is low, the block sets one shared request flag. That flag is the interrupt request line to the processor, and a separate 2-bit priority level for the request goes to an outside priority controller.

Software controls the block through a small synchronous register bus. Through it, software can:
- set the per-pin enables;
- read and clear the shared flag;
- read the synchronized levels of the pins, to find which pin is holding the request low;
- set the priority level.

A combinational wake output comes straight from the raw pins and the enables. It can bring the system out of a stopped-clock state without a clock edge.

The flag is sticky. It stays set after the causing pin's enable is removed, until software clears it. If an enabled pin is still low at the clear, the flag sets again at once.

Top module: `lvl_irq_aggr`

## Requirements
- R1: After synchronous reset: all enable bits are 0, the level field is 0, the flag is 0, `irq_req` is 0, `irq_level` is 0 and `bus_rdata` is 0.
- R2: A pin that falls low while its enable bit is 1 passes through a two-flop synchronizer. The flag, and with it `irq_req`, becomes 1 on the third rising edge after the pin falls. The flag reads as bit 0 at address 1.
- R3: A low pin whose enable bit is 0 never sets the flag.
- R4: `irq_req` equals the flag. It stays 1 after the enable of the causing pin is cleared and after that pin returns high, until software clears the flag.
- R5: A bus write to address 1 with data bit 0 equal to 0 clears the flag at that edge. A write there with bit 0 equal to 1 leaves the flag unchanged.
- R6: If a synchronized enabled pin is low at the edge where a clear is written, the set wins and the flag stays 1. A clear then takes effect only once no enabled synchronized pin is low.
- R7: Reads are registered. `bus_rdata` shows the register selected by `bus_addr` one edge later. Address 2 returns the synchronized pin levels, bit i for pin i.
- R8: `wake_req` is 1 exactly when some pin is low while its enable bit is 1. It follows the raw pins with no clock edge in between.
- R9: A write to address 3 stores data bits [1:0] as the level, which then appears on `irq_level` and reads back at address 3. Writes to other addresses leave the level unchanged.
- R10: A write to address 0 stores the 8 enable bits (bit i enables pin i), which read back at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_n | input | 8 | Active-low external request pins |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Shared interrupt request (the flag) |
| irq_level | output | 2 | Priority level for the request |
| wake_req | output | 1 | Combinational wake request |

## Verification
Each result falls due a fixed number of edges after its stimulus:
- The flag follows a pin change on the third edge, because of the two synchronizer flops and the flag register.
- A written enable or level acts at the write edge.
- Read data appears one edge after the address.
- The wake output responds within the same cycle.

The bench drives inputs on falling edges and samples shortly after them. A behavioural reference model advances at every rising edge and is compared on every cycle. Directed checks count exactly these edge delays, including the clear that is overridden while a pin is held low.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int REG_ENABLE = 0;
  localparam int REG_FLAG   = 1;
  localparam int REG_PINS   = 2;
  localparam int REG_LEVEL  = 3;
  localparam int FLAG_BIT   = 0;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  // Idle level of an active-low pin is high, so stages reset to 1.
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din[b]};
      end
      assign dout[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/extint_flag.sv
module extint_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_cond,
  input  logic clr_req,
  output logic flag
);
  // Set has priority over a software clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (set_cond) flag <= 1'b1;
    else if (clr_req)  flag <= 1'b0;
  end
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag,
  input  logic [NPINS-1:0]  pins_sync,
  output logic [NPINS-1:0]  enables,
  output logic [LVL_W-1:0]  level,
  output logic              clr_req,
  output logic [DATA_W-1:0] rdata
);
  logic wr_en, wr_lvl;
  logic [DATA_W-1:0] rd_next;

  assign wr_en   = we && (addr == ADDR_W'(REG_ENABLE));
  assign wr_lvl  = we && (addr == ADDR_W'(REG_LEVEL));
  assign clr_req = we && (addr == ADDR_W'(REG_FLAG)) && !wdata[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      enables <= '0;
      level   <= '0;
    end else begin
      if (wr_en)  enables <= wdata[NPINS-1:0];
      if (wr_lvl) level   <= wdata[LVL_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      ADDR_W'(REG_ENABLE): rd_next[NPINS-1:0] = enables;
      ADDR_W'(REG_FLAG):   rd_next[FLAG_BIT]  = flag;
      ADDR_W'(REG_PINS):   rd_next[NPINS-1:0] = pins_sync;
      ADDR_W'(REG_LEVEL):  rd_next[LVL_W-1:0] = level;
      default:             rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/lvl_irq_aggr.sv
module lvl_irq_aggr #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  ext_pin_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_level,
  output logic              wake_req
);
  localparam int SYNC_STAGES = 2;

  logic [NPINS-1:0] pin_s;
  logic [NPINS-1:0] en_q;
  logic             set_cond;
  logic             clr_req;
  logic             flag_q;

  extint_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ext_pin_n), .dout(pin_s)
  );

  extint_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .flag(flag_q), .pins_sync(pin_s), .enables(en_q), .level(irq_level),
    .clr_req(clr_req), .rdata(bus_rdata)
  );

  assign set_cond = |(~pin_s & en_q);

  extint_flag u_flag (
    .clk(clk), .rst(rst), .set_cond(set_cond), .clr_req(clr_req), .flag(flag_q)
  );

  assign irq_req  = flag_q;
  // Raw pins, no clock in the path: usable while the clock is stopped.
  assign wake_req = |(~ext_pin_n & en_q);
endmodule

// File: rtl/extint_chk.sv
module extint_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_req,
  input logic [LVL_W-1:0]  irq_level,
  input logic              set_cond
);
  logic clr_w, lvl_w;
  assign clr_w = bus_we && (bus_addr == ADDR_W'(1)) && !bus_wdata[0];
  assign lvl_w = bus_we && (bus_addr == ADDR_W'(3));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !clr_w) |=> irq_req);
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_cond |=> irq_req);
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_w && !set_cond) |=> !irq_req);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && !set_cond) |=> !irq_req);
  a_r9_level_stable: assert property (@(posedge clk) disable iff (rst)
    !lvl_w |=> $stable(irq_level));
endmodule

bind lvl_irq_aggr extint_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .irq_req(irq_req), .irq_level(irq_level), .set_cond(set_cond)
);

// File: tb/test_lvl_irq_aggr.sv
`timescale 1ns/1ps
module test_lvl_irq_aggr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pins = 8'hFF;
  logic [1:0] addr = 2'd0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  logic [1:0] lvl;
  logic       wake;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lvl_irq_aggr i_lvl_irq_aggr (
    .clk(clk), .rst(rst), .ext_pin_n(pins), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_req(irq), .irq_level(lvl),
    .wake_req(wake)
  );

  // Behavioural reference model
  logic [7:0] m_s1 = 8'hFF, m_s2 = 8'hFF, m_en = 8'h00, m_rd = 8'h00;
  logic [1:0] m_lvl = 2'd0;
  logic       m_flag = 1'b0;

  always @(posedge clk) begin
    logic [7:0] rd_n;
    logic       set, clr;
    if (rst) begin
      m_s1 = 8'hFF; m_s2 = 8'hFF; m_en = 0; m_lvl = 0; m_flag = 0; m_rd = 0;
    end else begin
      set = ((~m_s2 & m_en) != 0);
      clr = we && addr == 2'd1 && !wdata[0];
      case (addr)
        2'd0: rd_n = m_en;
        2'd1: rd_n = {7'd0, m_flag};
        2'd2: rd_n = m_s2;
        default: rd_n = {6'd0, m_lvl};
      endcase
      m_rd = rd_n;
      if (set) m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
      if (we && addr == 2'd0) m_en = wdata;
      if (we && addr == 2'd3) m_lvl = wdata[1:0];
      m_s2 = m_s1;
      m_s1 = pins;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      chk("R4 model irq", {7'd0, irq}, {7'd0, m_flag});
      chk("R8 model wake", {7'd0, wake}, {7'd0, ((~pins & m_en) != 0)});
      chk("R9 model level", {6'd0, lvl}, {6'd0, m_lvl});
      chk("R7 model rdata", rdata, m_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); #2; d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 rdata", rdata, 8'd0);
    chk("R1 level", {6'd0, lvl}, 8'd0);
    rd(2'd0, v); chk("R1 enables", v, 8'h00);

    // R3 disabled low pin
    @(negedge clk); pins = 8'hFE;
    cyc(6);
    chk("R3 irq stays low", {7'd0, irq}, 8'd0);
    chk("R8 wake off when disabled", {7'd0, wake}, 8'd0);
    @(negedge clk); pins = 8'hFF;
    cyc(3);

    // R10 enable register
    wr(2'd0, 8'h05);
    rd(2'd0, v); chk("R10 enable readback", v, 8'h05);

    // R2 timing, R8 wake
    @(negedge clk); pins = 8'hFB; #1;
    chk("R8 wake same cycle", {7'd0, wake}, 8'd1);
    cyc(2);
    chk("R2 not yet after two edges", {7'd0, irq}, 8'd0);
    cyc(1);
    chk("R2 set on third edge", {7'd0, irq}, 8'd1);
    rd(2'd1, v); chk("R2 flag readback", v, 8'h01);
    rd(2'd2, v); chk("R7 pin read", v, 8'hFB);

    // R6 clear while held low: set wins
    wr(2'd1, 8'h00); #2;
    chk("R6 set wins over clear", {7'd0, irq}, 8'd1);

    // R4 sticky after enable removed and pin released
    wr(2'd0, 8'h00);
    @(negedge clk); pins = 8'hFF;
    cyc(4);
    chk("R4 sticky", {7'd0, irq}, 8'd1);

    // R5 write 1 has no effect, write 0 clears
    wr(2'd1, 8'h01); #2;
    chk("R5 write one ignored", {7'd0, irq}, 8'd1);
    wr(2'd1, 8'h00); #2;
    chk("R5 clear", {7'd0, irq}, 8'd0);

    // R6 re-set after clear when pin stays low
    wr(2'd0, 8'h80);
    @(negedge clk); pins = 8'h7F;
    cyc(4);
    chk("R6 set by pin7", {7'd0, irq}, 8'd1);
    wr(2'd0, 8'h00);
    cyc(3);
    wr(2'd1, 8'h00); #2;
    chk("R6 clear works with enable off", {7'd0, irq}, 8'd0);
    wr(2'd0, 8'h80);
    cyc(1);
    chk("R6 sets again while low", {7'd0, irq}, 8'd1);

    // R9 level
    wr(2'd3, 8'hFE); #2;
    chk("R9 level out", {6'd0, lvl}, 8'd2);
    rd(2'd3, v); chk("R9 level readback", v, 8'h02);
    wr(2'd0, 8'h80); #2;
    chk("R9 level unchanged", {6'd0, lvl}, 8'd2);

    @(negedge clk); pins = 8'hFF;
    cyc(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule